// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is the serial front end of a byte-wide random access store. An SPI master frames each command with the active-low select. It shifts in an opcode and, where the command needs one, a 24-bit address. Data then streams in either direction, one byte after another, until the select is released. The storage is an on-chip array whose size is set by `ADDR_W`, so the block runs without any outside memory model. Writes finish at the serial bit rate, with no busy phase and no polling.

All pins are sampled by the block's own clock through a parameterised synchroniser. Because of this, the serial clock must run several times slower than the block clock. Writes are gated by three things: a write-enable latch, a two-bit protected-region field, and a status-lock bit that takes effect together with an active-low guard pin. A pause pin freezes a transfer in mid-byte. A sleep command makes the block deaf to everything except the wake command.

Top module: `spi_ram_slave`

## Requirements
- R1: Of the 24 address bits received (MSB first, after the opcode), only the low `ADDR_W` bits select a byte. The upper bits have no effect.
- R2: READ (03h) and WRITE (02h) stream bytes from the start address, adding one per byte. The address wraps from the top of the array to 0, and the transfer ends only when `ss_n` rises.
- R3: While the write-enable latch (status bit 1) is clear, WRITE data and WRSR (01h) data are discarded.
- R4: WREN (06h) sets status bit 1, and WRDI (04h) clears it. A WRSR or WRITE command also clears it when its frame ends. The change becomes visible once `ss_n` rises.
- R5: The status register is 00h after reset. RDSR (05h) returns it, MSB first, on every byte until the frame ends. An accepted WRSR loads bits 7, 6..2 and 0 from its first data byte. Bits 6, 5, 4 and 0 have no effect on behaviour.
- R6: Status bits 3:2 select the protected region: 00 none, 01 the top quarter of the array, 10 the top half, 11 all of it. Write bytes that fall inside the region are discarded.
- R7: While status bit 7 is 1 and `wr_guard_n` is low, WRSR is rejected.
- R8: `miso_oe` is low while `ss_n` is high and while a pause is active.
- R9: A low `pause_n` during a frame suspends the transfer. Serial clock edges are then ignored. When `pause_n` returns high, the transfer resumes at the bit where it stopped.
- R10: After SLEEP (B9h), every opcode except WAKE (ABh) is ignored. The block returns to normal operation after WAKE.
- R11: An opcode other than the eight listed above is ignored, together with everything after it, until `ss_n` rises.
- R12: Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) work. `mosi` is sampled on rising edges and `miso` changes on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` (low means high impedance) |
| pause_n | input | 1 | Active-low transfer pause |
| wr_guard_n | input | 1 | Active-low guard that, with status bit 7, locks the status register |

## Verification
The bench builds the block with `ADDR_W = 6`, which gives a 64-byte array. At that size a single streaming frame covers every location, and the wrap from 63 to 0 comes within every long transfer. Each of the four protection settings is swept over the full array, with the expected contents computed from the address arithmetic. The same frames are driven in both clock polarities. The pause and sleep cases are also run at this size, with the pause placed in the middle of a byte.

// File: rtl/spi_ram_pkg.sv
package spi_ram_pkg;

   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_SLEEP = 8'hB9;
   localparam logic [7:0] OP_WAKE  = 8'hAB;

   typedef enum logic [1:0] {
      PH_OPC,
      PH_ADDR,
      PH_DATA,
      PH_SKIP
   } phase_e;

   // Region guarded by the two-bit protect field, given the two top address bits.
   function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return (top2 == 2'b11);
         2'b10:   return top2[1];
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/spi_ram_sync.sv
module spi_ram_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin : elab_chk
      assert (WIDTH >= 1 && STAGES <= 4)
         else $error("spi_ram_sync: WIDTH must be >= 1 and STAGES <= 4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= RST_VAL;
            else        stg_q <= d;
         end
         assign q = stg_q;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= {STAGES{RST_VAL}};
            else        stg_q <= {stg_q[STAGES-2:0], d};
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_ram_status.sv
module spi_ram_status
   import spi_ram_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wel_set,
   input  logic       wel_clr,
   input  logic       wr_req,
   input  logic [7:0] wr_byte,
   input  logic       guard_n,
   input  logic [1:0] tgt_top2,
   output logic [7:0] stat,
   output logic       mem_ok
);

   logic [7:0] stat_q;
   logic       wrsr_ok;

   assign wrsr_ok = stat_q[1] && !(stat_q[7] && !guard_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 8'h00;
      end else begin
         if (wr_req && wrsr_ok)
            stat_q <= {wr_byte[7:2], stat_q[1], wr_byte[0]};
         if (wel_set)
            stat_q[1] <= 1'b1;
         else if (wel_clr)
            stat_q[1] <= 1'b0;
      end
   end

   assign stat   = stat_q;
   assign mem_ok = stat_q[1] && !region_locked(stat_q[3:2], tgt_top2);

   // R3: non-latch status bits change only while the latch was set
   a_r3_stat_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({stat_q[7:2], stat_q[0]}) |-> $past(stat_q[1]));

   // R7: status bits never change while locked by bit 7 and the guard pin
   a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({stat_q[7:2], stat_q[0]}) |-> !($past(stat_q[7]) && !$past(guard_n)));

endmodule

// File: rtl/spi_ram_array.sv
module spi_ram_array #(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/spi_ram_slave.sv
module spi_ram_slave
   import spi_ram_pkg::*;
#(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_n,
   input  logic sclk,
   input  logic mosi,
   output logic miso,
   output logic miso_oe,
   input  logic pause_n,
   input  logic wr_guard_n
);

   localparam int unsigned NPIN = 5;
   localparam logic [NPIN-1:0] PIN_RST = 5'b10011;

   initial begin : elab_chk
      assert (ADDR_W >= 2 && ADDR_W <= 24)
         else $error("spi_ram_slave: ADDR_W must lie in 2..24");
   end

   // synchronised pins
   logic [NPIN-1:0] pins_s;
   logic s_ss, s_sck, s_mosi, s_pause, s_guard;

   spi_ram_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ss_n, sclk, mosi, pause_n, wr_guard_n}),
      .q     (pins_s)
   );
   assign {s_ss, s_sck, s_mosi, s_pause, s_guard} = pins_s;

   // frame and edge state
   logic              sck_d, in_frame_q, hold_q;
   logic              sck_rise, sck_fall, frame_end, byte_done;
   logic [2:0]        bit_cnt_q;
   logic [6:0]        in_sr_q;
   logic [7:0]        in_byte;
   logic [7:0]        out_sr_q;
   logic              miso_q;
   phase_e            phase_q;
   logic [7:0]        cmd_q;
   logic              cmd_valid_q, wrsr_done_q, asleep_q;
   logic [1:0]        addr_cnt_q;
   logic [ADDR_W-1:0] addr_acc_q, addr_next, addr_q, rd_addr;

   assign sck_rise  = in_frame_q && !hold_q && s_sck && !sck_d;
   assign sck_fall  = in_frame_q && !hold_q && !s_sck && sck_d;
   assign frame_end = in_frame_q && s_ss && !hold_q;
   assign byte_done = sck_rise && (bit_cnt_q == 3'd7);
   assign in_byte   = {in_sr_q, s_mosi};
   assign addr_next = ADDR_W'({addr_acc_q, in_byte});
   assign rd_addr   = (phase_q == PH_ADDR) ? addr_next : addr_q;

   // status and array
   logic [7:0] stat, rd_data;
   logic       mem_ok, mem_we, stat_wr, wel_set, wel_clr;

   assign mem_we  = byte_done && (phase_q == PH_DATA) && (cmd_q == OP_WRITE) && mem_ok;
   assign stat_wr = byte_done && (phase_q == PH_DATA) && (cmd_q == OP_WRSR) && !wrsr_done_q;
   assign wel_set = frame_end && cmd_valid_q && (cmd_q == OP_WREN);
   assign wel_clr = frame_end && cmd_valid_q &&
                    ((cmd_q == OP_WRDI) || (cmd_q == OP_WRSR) || (cmd_q == OP_WRITE));

   spi_ram_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wel_set  (wel_set),
      .wel_clr  (wel_clr),
      .wr_req   (stat_wr),
      .wr_byte  (in_byte),
      .guard_n  (s_guard),
      .tgt_top2 (addr_q[ADDR_W-1 -: 2]),
      .stat     (stat),
      .mem_ok   (mem_ok)
   );

   spi_ram_array #(.AW(ADDR_W)) u_array (
      .clk   (clk),
      .we    (mem_we),
      .waddr (addr_q),
      .wdata (in_byte),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   // pause tracking: taken only while selected, dropped as soon as the pin rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         sck_d <= s_sck;
         if (s_pause)                      hold_q <= 1'b0;
         else if (!s_ss && in_frame_q)     hold_q <= 1'b1;
      end
   end

   // command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q  <= 1'b0;
         bit_cnt_q   <= '0;
         in_sr_q     <= '0;
         out_sr_q    <= '0;
         miso_q      <= 1'b0;
         phase_q     <= PH_OPC;
         cmd_q       <= '0;
         cmd_valid_q <= 1'b0;
         wrsr_done_q <= 1'b0;
         asleep_q    <= 1'b0;
         addr_cnt_q  <= '0;
         addr_acc_q  <= '0;
         addr_q      <= '0;
      end else if (frame_end) begin
         in_frame_q  <= 1'b0;
         bit_cnt_q   <= '0;
         phase_q     <= PH_OPC;
         cmd_valid_q <= 1'b0;
         wrsr_done_q <= 1'b0;
         addr_cnt_q  <= '0;
         if (cmd_valid_q && cmd_q == OP_SLEEP) asleep_q <= 1'b1;
         if (cmd_valid_q && cmd_q == OP_WAKE)  asleep_q <= 1'b0;
      end else begin
         if (!s_ss) in_frame_q <= 1'b1;
         if (sck_rise) begin
            in_sr_q   <= in_byte[6:0];
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
               case (phase_q)
                  PH_OPC: begin
                     cmd_q <= in_byte;
                     if (asleep_q && in_byte != OP_WAKE) begin
                        phase_q <= PH_SKIP;
                     end else begin
                        case (in_byte)
                           OP_READ, OP_WRITE: begin
                              phase_q     <= PH_ADDR;
                              cmd_valid_q <= 1'b1;
                           end
                           OP_RDSR: begin
                              phase_q     <= PH_DATA;
                              cmd_valid_q <= 1'b1;
                              out_sr_q    <= stat;
                           end
                           OP_WRSR: begin
                              phase_q     <= PH_DATA;
                              cmd_valid_q <= 1'b1;
                           end
                           OP_WREN, OP_WRDI, OP_SLEEP, OP_WAKE: begin
                              phase_q     <= PH_SKIP;
                              cmd_valid_q <= 1'b1;
                           end
                           default: phase_q <= PH_SKIP;
                        endcase
                     end
                  end
                  PH_ADDR: begin
                     addr_acc_q <= addr_next;
                     addr_cnt_q <= addr_cnt_q + 2'd1;
                     if (addr_cnt_q == 2'd2) begin
                        phase_q <= PH_DATA;
                        if (cmd_q == OP_READ) begin
                           out_sr_q <= rd_data;
                           addr_q   <= addr_next + 1'b1;
                        end else begin
                           addr_q   <= addr_next;
                        end
                     end
                  end
                  PH_DATA: begin
                     if (cmd_q == OP_READ) begin
                        out_sr_q <= rd_data;
                        addr_q   <= addr_q + 1'b1;
                     end else if (cmd_q == OP_WRITE) begin
                        addr_q   <= addr_q + 1'b1;
                     end else if (cmd_q == OP_RDSR) begin
                        out_sr_q <= stat;
                     end else begin
                        wrsr_done_q <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end else if (sck_fall) begin
            miso_q   <= out_sr_q[7];
            out_sr_q <= {out_sr_q[6:0], 1'b0};
         end
      end
   end

   assign miso    = miso_q;
   assign miso_oe = in_frame_q && !hold_q;

   // R9: nothing in the shift path moves while paused
   a_r9_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q && $past(hold_q) |-> $stable(bit_cnt_q) && $stable(addr_q) && $stable(out_sr_q));

   // R10: no array write while asleep
   a_r10_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      asleep_q |-> !mem_we);

   // R4: latch is clear after a WRITE, WRSR or WRDI frame closes
   a_r4_wel_drop_end: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end && cmd_valid_q &&
      (cmd_q == OP_WRITE || cmd_q == OP_WRSR || cmd_q == OP_WRDI) |=> !stat[1]);

   // R2: every stored byte advances the address by one, wrapping naturally
   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

endmodule

// File: tb/spi_ram_slave_tb.sv
`timescale 1ns/1ps
module spi_ram_slave_tb;

   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0, pause_n = 1'b1, wr_guard_n = 1'b1;
   logic miso, miso_oe;

   always #2 clk = ~clk;

   spi_ram_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ss_n       (ss_n),
      .sclk       (sclk),
      .mosi       (mosi),
      .miso       (miso),
      .miso_oe    (miso_oe),
      .pause_n    (pause_n),
      .wr_guard_n (wr_guard_n)
   );

   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   logic mode3 = 1'b0;
   logic [7:0] exp_mem [DEPTH];
   logic [7:0] exp_stat = 8'h00;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a, input int seed);
      return 8'((a * 37 + seed * 11 + 5) & 255);
   endfunction

   function automatic bit prot(input int a);
      case (exp_stat[3:2])
         2'b00:   return 1'b0;
         2'b01:   return a >= (DEPTH * 3) / 4;
         2'b10:   return a >= DEPTH / 2;
         default: return 1'b1;
      endcase
   endfunction

   // one bit: fall, present data, wait, sample, rise, wait
   task automatic bit_x(input logic b, output logic r);
      sclk = 1'b0;
      mosi = b;
      tick(HALF);
      r = miso;
      sclk = 1'b1;
      tick(HALF);
   endtask

   task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, input int pause_after);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_x(tx[i], r);
         rx[i] = r;
         if (pause_after == i) begin
            pause_n = 1'b0;
            tick(8);
            chk("R8 miso_oe during pause", miso_oe, 0);
            for (int k = 0; k < 3; k++) begin
               sclk = 1'b0; tick(HALF);
               sclk = 1'b1; tick(HALF);
            end
            pause_n = 1'b1;
            tick(8);
            chk("R8 miso_oe after pause", miso_oe, 1);
         end
      end
   endtask

   task automatic fbegin();
      sclk = mode3;
      tick(2);
      ss_n = 1'b0;
      tick(HALF);
   endtask

   task automatic fend();
      sclk = mode3;
      tick(HALF);
      ss_n = 1'b1;
      tick(HALF + 6);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] rx;
      fbegin(); byte_x(op, rx, -1); fend();
   endtask

   task automatic wren();
      cmd1(8'h06);
      exp_stat[1] = 1'b1;
   endtask

   task automatic rdsr_chk(input string req, input int nbytes);
      logic [7:0] rx;
      fbegin();
      byte_x(8'h05, rx, -1);
      for (int i = 0; i < nbytes; i++) begin
         byte_x(8'h00, rx, -1);
         chk(req, rx, exp_stat);
      end
      fend();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] rx;
      fbegin(); byte_x(8'h01, rx, -1); byte_x(v, rx, -1); fend();
      if (exp_stat[1] && !(exp_stat[7] && !wr_guard_n))
         exp_stat = {v[7:2], exp_stat[1], v[0]};
      exp_stat[1] = 1'b0;
   endtask

   task automatic wr_stream(input logic [23:0] a24, input int n, input int seed);
      logic [7:0] rx;
      fbegin();
      byte_x(8'h02, rx, -1);
      byte_x(a24[23:16], rx, -1); byte_x(a24[15:8], rx, -1); byte_x(a24[7:0], rx, -1);
      for (int i = 0; i < n; i++) begin
         int a;
         a = (int'(a24[AW-1:0]) + i) % DEPTH;
         byte_x(pat(a, seed), rx, -1);
         if (exp_stat[1] && !prot(a)) exp_mem[a] = pat(a, seed);
      end
      fend();
      exp_stat[1] = 1'b0;
   endtask

   task automatic rd_stream(input string req, input logic [23:0] a24, input int n, input int pause_byte);
      logic [7:0] rx;
      fbegin();
      chk("R8 miso_oe in frame", miso_oe, 1);
      byte_x(8'h03, rx, -1);
      byte_x(a24[23:16], rx, -1); byte_x(a24[15:8], rx, -1); byte_x(a24[7:0], rx, -1);
      for (int i = 0; i < n; i++) begin
         int a;
         a = (int'(a24[AW-1:0]) + i) % DEPTH;
         byte_x(8'h00, rx, (i == pause_byte) ? 4 : -1);
         chk(req, rx, exp_mem[a]);
      end
      fend();
      chk("R8 miso_oe after frame", miso_oe, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] rx;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R5, R8 reset state
      chk("R8 miso_oe idle after reset", miso_oe, 0);
      rdsr_chk("R5 status after reset", 1);

      // R4 WREN, R5 repeated status bytes
      wren();
      rdsr_chk("R4 R5 status after WREN", 3);

      // R1 R2 full-array write from 60 with junk upper address bits, wrap
      wr_stream(24'hFFFF3C, DEPTH, 1);
      rdsr_chk("R4 latch cleared by WRITE end", 1);
      rd_stream("R1 R2 streaming read with wrap", 24'hA50000, DEPTH + 2, -1);

      // R12 mode 3 read at odd start with upper bits set
      mode3 = 1'b1;
      rd_stream("R12 R1 mode 3 read", 24'h7E013D, 6, -1);
      wren();
      wr_stream(24'h000005, 3, 7);
      rd_stream("R12 mode 3 write readback", 24'h000004, 5, -1);
      mode3 = 1'b0;

      // R3 writes without latch discarded
      wr_stream(24'h00000A, 4, 9);
      rd_stream("R3 write without latch", 24'h000008, 8, -1);
      wrsr(8'h0C);
      rdsr_chk("R3 WRSR without latch", 1);

      // R4 WRDI
      wren();
      cmd1(8'h04);
      exp_stat[1] = 1'b0;
      rdsr_chk("R4 latch cleared by WRDI", 1);

      // R5 don't-care bits
      wren();
      wrsr(8'h71);
      rdsr_chk("R5 WRSR loads bits", 1);
      wren();
      wr_stream(24'h000020, 4, 3);
      rd_stream("R5 spare bits have no effect", 24'h000020, 4, -1);

      // R6 protection sweep over the whole array
      for (int bp = 0; bp < 4; bp++) begin
         wren();
         wrsr(8'(bp << 2));
         rdsr_chk("R6 protect field readback", 1);
         wren();
         wr_stream(24'h000000, DEPTH, bp + 20);
         rd_stream("R6 protected region", 24'h000000, DEPTH, -1);
      end
      wren();
      wrsr(8'h00);

      // R7 status lock
      wren();
      wrsr(8'h80);
      rdsr_chk("R7 lock bit set", 1);
      wr_guard_n = 1'b0;
      wren();
      wrsr(8'h8C);
      rdsr_chk("R7 WRSR rejected while locked", 1);
      wr_guard_n = 1'b1;
      wren();
      wrsr(8'h00);
      rdsr_chk("R7 WRSR accepted with guard high", 1);

      // R11 unknown opcode
      wren();
      fbegin();
      byte_x(8'h5A, rx, -1); byte_x(8'h02, rx, -1); byte_x(8'h00, rx, -1);
      byte_x(8'h00, rx, -1); byte_x(8'h05, rx, -1); byte_x(8'hEE, rx, -1);
      fend();
      rdsr_chk("R11 unknown opcode leaves latch", 1);
      rd_stream("R11 unknown opcode leaves memory", 24'h000005, 1, -1);

      // R10 sleep
      cmd1(8'hB9);
      cmd1(8'h04);
      fbegin();
      byte_x(8'h02, rx, -1); byte_x(8'h00, rx, -1); byte_x(8'h00, rx, -1);
      byte_x(8'h07, rx, -1); byte_x(8'hAA, rx, -1);
      fend();
      cmd1(8'hAB);
      rdsr_chk("R10 commands ignored while asleep", 1);
      rd_stream("R10 write ignored while asleep", 24'h000007, 1, -1);
      cmd1(8'h04);
      exp_stat[1] = 1'b0;
      rdsr_chk("R10 normal after wake", 1);

      // R9 pause in mid-byte during a read, both modes
      rd_stream("R9 read across pause", 24'h00003E, 4, 1);
      mode3 = 1'b1;
      rd_stream("R9 R12 read across pause mode 3", 24'h000010, 3, 0);
      mode3 = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule